// File: doc/BRIEF.md
# Programmable Chip Select Unit

The unit decodes the CPU address bus into four external chip-select pins: one for program memory, one for the I/O page and two general-purpose selects. Each select has its own enable, active polarity, address range, timing qualifier and clock-stretch request of 0 to 3 cycles. The qualifier is either the E-clock high phase or the whole address-valid time. A general-purpose select can be set to follow a memory expansion window hit instead of an address range, whatever bank the window points at.

When several ranges overlap, a fixed ordering and one priority bit choose a single winning select. Link options can then mirror the winner onto a second pin. The stretch request of the winner goes out as one count for the bus controller, which extends the bus cycle itself. Configuration enters through an 8-bit register write port with eight locations.

Decoding from address and phase to the pins is combinational. A configuration write takes effect from the clock edge that captures it.

Top module: `chip_select_unit`

## Requirements
- R1: After reset every configuration byte is zero: all selects are disabled and active-low, so all four pins read 1 and `stretch` reads 0.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr` on the rising edge and is used from that edge onward. No write happens while `wr_en` is low. The locations are: 0 program config, 1 I/O config, 2 GP1 config, 3 GP1 base, 4 GP1 size, 5 GP2 config, 6 GP2 base, 7 GP2 size.
- R3: Every config byte has bit0 enable and bit1 timing mode. With timing mode 0 a select can assert only while `e_high` is 1. With timing mode 1 it can assert only while `addr_valid` is 1.
- R4: The I/O select covers 0x1000–0x1FFF when I/O config bit3 is 0, and 0x0000–0x1FFF when it is 1.
- R5: The program select covers 0x8000–0xFFFF when program config bit3 is 0, and the whole 64 KB space when it is 1.
- R6: A general-purpose select with config bit3 at 0 matches an aligned block. The block starts at base byte × 256 and holds 256 × 2^n bytes, where n is size-register bits [2:0].
- R7: A general-purpose select with config bit3 at 1 ignores the address. It matches while `win_hit[k]` is 1, where k is size-register bit3.
- R8: At most one select wins. The I/O select beats every other select.
- R9: Program config bit7 at 0 lets the program select beat both general-purpose selects. At 1 the general-purpose selects beat it. GP1 always beats GP2.
- R10: GP1 config bit7 mirrors a GP1 win onto the GP2 pin. Bit6 of either general-purpose config mirrors that select's win onto the program pin.
- R11: Config bit2 sets the polarity (1 = active high). Polarity is applied after linking, so each pin follows its own polarity bit.
- R12: `stretch` equals config bits [5:4] of the winning select, and is 0 when no select wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration location |
| wr_data | input | 8 | Configuration data |
| cpu_addr | input | 16 | CPU address |
| e_high | input | 1 | E-clock high phase indicator |
| addr_valid | input | 1 | Address-valid indicator |
| win_hit | input | 2 | Memory expansion window hit flags |
| cs_prog | output | 1 | Program chip select pin |
| cs_io | output | 1 | I/O chip select pin |
| cs_gp1 | output | 1 | General-purpose select 1 pin |
| cs_gp2 | output | 1 | General-purpose select 2 pin |
| stretch | output | 2 | Clock-stretch cycles requested by the winning select |

## Verification
The pins and `stretch` depend on the address, phase and window inputs with no register in the path. Their results are therefore due in the same cycle the stimulus is applied. The bench drives these inputs on the falling edge and samples one nanosecond later, well before the next rising edge. A configuration write is captured on a rising edge, so the bench checks its effect at the following falling edge. A write with the strobe low is checked at the pins in the same way.

// File: rtl/csu_pkg.sv
package csu_pkg;
    localparam int CSU_ADDR_W = 16;
    localparam int CSU_DATA_W = 8;
    localparam int CSU_REG_AW = 3;
    localparam int CSU_NREGS  = 1 << CSU_REG_AW;
    localparam int CSU_STR_W  = 2;
    localparam int CSU_NWIN   = 2;
    localparam int CSU_PAGE_SH = 8;

    // Bit layout of every select configuration byte
    typedef struct packed {
        logic                 flag7;     // prog: GP priority; GP1: link into GP2
        logic                 link_prog; // GP: mirror into program pin
        logic [CSU_STR_W-1:0] stretch;
        logic                 mode;      // prog/io: size; GP: window tracking
        logic                 pol;       // 1 = active high
        logic                 av;        // 1 = address-valid qualified
        logic                 en;
    } sel_cfg_t;

    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_IO   = 3'd1,
        WIN_PROG = 3'd2,
        WIN_GP1  = 3'd3,
        WIN_GP2  = 3'd4
    } winner_e;

    localparam logic [CSU_REG_AW-1:0] LOC_PROG = 3'd0;
    localparam logic [CSU_REG_AW-1:0] LOC_IO   = 3'd1;
    localparam logic [CSU_REG_AW-1:0] LOC_GP0  = 3'd2; // GP1 block start, GP2 at +3
endpackage

// File: rtl/csu_regs.sv
module csu_regs
    import csu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CSU_REG_AW-1:0] wr_addr,
    input  logic [CSU_DATA_W-1:0] wr_data,
    output sel_cfg_t              prog_cfg,
    output sel_cfg_t              io_cfg,
    output sel_cfg_t              gp_cfg  [2],
    output logic [CSU_DATA_W-1:0] gp_base [2],
    output logic [CSU_DATA_W-1:0] gp_size [2]
);
    logic [CSU_DATA_W-1:0] regs_q [CSU_NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CSU_NREGS; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_addr] <= wr_data;
        end
    end

    assign prog_cfg = sel_cfg_t'(regs_q[LOC_PROG]);
    assign io_cfg   = sel_cfg_t'(regs_q[LOC_IO]);

    for (genvar g = 0; g < 2; g++) begin : g_gp_fields
        localparam int BASE_LOC = int'(LOC_GP0) + 3 * g;
        assign gp_cfg[g]  = sel_cfg_t'(regs_q[BASE_LOC]);
        assign gp_base[g] = regs_q[BASE_LOC + 1];
        assign gp_size[g] = regs_q[BASE_LOC + 2];
    end

    // R2: stored byte follows the write that was strobed
    assert_write_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(wr_addr)] == $past(wr_data));
    // R2: no strobe, no change
    assert_no_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> regs_q[$past(wr_addr)] == $past(regs_q[wr_addr]));
endmodule

// File: rtl/csu_fixed_match.sv
module csu_fixed_match
    import csu_pkg::*;
(
    input  logic [CSU_ADDR_W-1:0] cpu_addr,
    input  logic                  e_high,
    input  logic                  addr_valid,
    input  sel_cfg_t              prog_cfg,
    input  sel_cfg_t              io_cfg,
    output logic                  prog_hit,
    output logic                  io_hit
);
    localparam int IO_TOP = 13; // 8 KB page boundary bit

    logic prog_qual, io_qual, prog_rng, io_rng;

    always_comb begin
        prog_qual = prog_cfg.av ? addr_valid : e_high;
        io_qual   = io_cfg.av   ? addr_valid : e_high;
        prog_rng  = prog_cfg.mode | cpu_addr[CSU_ADDR_W-1];
        io_rng    = (cpu_addr[CSU_ADDR_W-1:IO_TOP] == '0) &&
                    (io_cfg.mode || cpu_addr[IO_TOP-1]);
        prog_hit  = prog_cfg.en & prog_qual & prog_rng;
        io_hit    = io_cfg.en & io_qual & io_rng;
    end
endmodule

// File: rtl/csu_gp_match.sv
module csu_gp_match
    import csu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CSU_ADDR_W-1:0] cpu_addr,
    input  logic                  e_high,
    input  logic                  addr_valid,
    input  logic [CSU_NWIN-1:0]   win_hit,
    input  sel_cfg_t              cfg,
    input  logic [CSU_DATA_W-1:0] base,
    input  logic [CSU_DATA_W-1:0] size,
    output logic                  hit
);
    localparam int CODE_W = 3;
    localparam int WIN_BIT = CODE_W;

    logic [CSU_ADDR_W-1:0] span_mask;
    logic [CSU_ADDR_W-1:0] base_addr;
    logic                  rng, qual, win_sel;
    logic                  unused_size_bits;

    always_comb begin
        span_mask = ({{(CSU_ADDR_W-1){1'b0}}, 1'b1} << (CSU_PAGE_SH + int'(size[CODE_W-1:0]))) - 1'b1;
        base_addr = {base, {CSU_PAGE_SH{1'b0}}};
        win_sel   = win_hit[size[WIN_BIT]];
        rng       = cfg.mode ? win_sel : (((cpu_addr ^ base_addr) & ~span_mask) == '0);
        qual      = cfg.av ? addr_valid : e_high;
        hit       = cfg.en & qual & rng;
    end

    assign unused_size_bits = ^size[CSU_DATA_W-1:WIN_BIT+1];

    // R3: a hit never appears outside its timing qualifier
    assert_hit_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cfg.en && (cfg.av ? addr_valid : e_high)));
endmodule

// File: rtl/csu_resolve.sv
module csu_resolve
    import csu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_hit,
    input  logic                 prog_hit,
    input  logic [1:0]           gp_hit,
    input  sel_cfg_t             prog_cfg,
    input  sel_cfg_t             io_cfg,
    input  sel_cfg_t             gp_cfg [2],
    output logic                 cs_prog,
    output logic                 cs_io,
    output logic                 cs_gp1,
    output logic                 cs_gp2,
    output logic [CSU_STR_W-1:0] stretch
);
    winner_e win;
    logic    io_act, prog_act, gp1_act, gp2_act;
    logic    prog_drv, gp2_drv;
    logic    unused_cfg_bits;

    always_comb begin
        win = WIN_NONE;
        if (io_hit) begin
            win = WIN_IO;
        end else if (prog_cfg.flag7) begin
            if      (gp_hit[0]) win = WIN_GP1;
            else if (gp_hit[1]) win = WIN_GP2;
            else if (prog_hit)  win = WIN_PROG;
        end else begin
            if      (prog_hit)  win = WIN_PROG;
            else if (gp_hit[0]) win = WIN_GP1;
            else if (gp_hit[1]) win = WIN_GP2;
        end
    end

    always_comb begin
        io_act   = (win == WIN_IO);
        prog_act = (win == WIN_PROG);
        gp1_act  = (win == WIN_GP1);
        gp2_act  = (win == WIN_GP2);
        gp2_drv  = gp2_act | (gp1_act & gp_cfg[0].flag7);
        prog_drv = prog_act | (gp1_act & gp_cfg[0].link_prog)
                            | (gp2_act & gp_cfg[1].link_prog);
        cs_io    = ~(io_act   ^ io_cfg.pol);
        cs_prog  = ~(prog_drv ^ prog_cfg.pol);
        cs_gp1   = ~(gp1_act  ^ gp_cfg[0].pol);
        cs_gp2   = ~(gp2_drv  ^ gp_cfg[1].pol);
    end

    always_comb begin
        unique case (win)
            WIN_IO:   stretch = io_cfg.stretch;
            WIN_PROG: stretch = prog_cfg.stretch;
            WIN_GP1:  stretch = gp_cfg[0].stretch;
            WIN_GP2:  stretch = gp_cfg[1].stretch;
            default:  stretch = '0;
        endcase
    end

    assign unused_cfg_bits = ^{io_cfg.flag7, io_cfg.link_prog, io_cfg.mode, io_cfg.av, io_cfg.en,
                               prog_cfg.link_prog, prog_cfg.mode, prog_cfg.av, prog_cfg.en,
                               gp_cfg[1].flag7, gp_cfg[0].mode, gp_cfg[0].av, gp_cfg[0].en,
                               gp_cfg[1].mode, gp_cfg[1].av, gp_cfg[1].en};

    // R8: only one select can win
    assert_single_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_act, prog_act, gp1_act, gp2_act}));
    // R8: an I/O hit always wins
    assert_io_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (cs_io == io_cfg.pol) && !gp1_act && !gp2_act);
    // R12: nothing selected means no stretch
    assert_idle_stretch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_hit || prog_hit || (|gp_hit)) |-> stretch == '0);
endmodule

// File: rtl/chip_select_unit.sv
module chip_select_unit
    import csu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CSU_REG_AW-1:0] wr_addr,
    input  logic [CSU_DATA_W-1:0] wr_data,
    input  logic [CSU_ADDR_W-1:0] cpu_addr,
    input  logic                  e_high,
    input  logic                  addr_valid,
    input  logic [CSU_NWIN-1:0]   win_hit,
    output logic                  cs_prog,
    output logic                  cs_io,
    output logic                  cs_gp1,
    output logic                  cs_gp2,
    output logic [CSU_STR_W-1:0]  stretch
);
    sel_cfg_t              prog_cfg, io_cfg;
    sel_cfg_t              gp_cfg  [2];
    logic [CSU_DATA_W-1:0] gp_base [2];
    logic [CSU_DATA_W-1:0] gp_size [2];
    logic                  prog_hit, io_hit;
    logic [1:0]            gp_hit;

    csu_regs i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_cfg(prog_cfg), .io_cfg(io_cfg), .gp_cfg(gp_cfg),
        .gp_base(gp_base), .gp_size(gp_size)
    );

    csu_fixed_match i_fixed (
        .cpu_addr(cpu_addr), .e_high(e_high), .addr_valid(addr_valid),
        .prog_cfg(prog_cfg), .io_cfg(io_cfg), .prog_hit(prog_hit), .io_hit(io_hit)
    );

    for (genvar g = 0; g < 2; g++) begin : g_gp
        csu_gp_match i_gp (
            .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .e_high(e_high),
            .addr_valid(addr_valid), .win_hit(win_hit), .cfg(gp_cfg[g]),
            .base(gp_base[g]), .size(gp_size[g]), .hit(gp_hit[g])
        );
    end

    csu_resolve i_resolve (
        .clk(clk), .rst_n(rst_n), .io_hit(io_hit), .prog_hit(prog_hit), .gp_hit(gp_hit),
        .prog_cfg(prog_cfg), .io_cfg(io_cfg), .gp_cfg(gp_cfg),
        .cs_prog(cs_prog), .cs_io(cs_io), .cs_gp1(cs_gp1), .cs_gp2(cs_gp2), .stretch(stretch)
    );
endmodule

// File: tb/test_chip_select_unit.sv
module test_chip_select_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] cpu_addr = '0;
    logic        e_high = 1'b0;
    logic        addr_valid = 1'b0;
    logic [1:0]  win_hit = '0;
    logic        cs_prog, cs_io, cs_gp1, cs_gp2;
    logic [1:0]  stretch;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chip_select_unit i_chip_select_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_addr(cpu_addr), .e_high(e_high), .addr_valid(addr_valid), .win_hit(win_hit),
        .cs_prog(cs_prog), .cs_io(cs_io), .cs_gp1(cs_gp1), .cs_gp2(cs_gp2), .stretch(stretch)
    );

    // pins checked as {prog, io, gp1, gp2}
    task automatic check(input string tag, input logic [3:0] exp_pins, input logic [1:0] exp_str);
        logic [3:0] got;
        #1;
        got = {cs_prog, cs_io, cs_gp1, cs_gp2};
        n_checks++;
        if (got !== exp_pins || stretch !== exp_str) begin
            n_errors++;
            $display("FAIL %s: pins=%b stretch=%0d expected pins=%b stretch=%0d",
                     tag, got, stretch, exp_pins, exp_str);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic e, input logic v, input logic [1:0] w);
        @(negedge clk);
        cpu_addr = a; e_high = e; addr_valid = v; win_hit = w;
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        drive(16'h1000, 1'b1, 1'b1, 2'b11);
        check("R1 reset idle pins", 4'b1111, 2'd0);
        drive(16'hFFFF, 1'b1, 1'b1, 2'b11);
        check("R1 reset high address", 4'b1111, 2'd0);
    endtask

    task automatic t_write_strobe();
        do_reset();
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 3'd1; wr_data = 8'h0B;
        @(negedge clk);
        drive(16'h1000, 1'b1, 1'b1, 2'b00);
        check("R2 no strobe no write", 4'b1111, 2'd0);
        write_reg(3'd1, 8'h0B);
        drive(16'h1000, 1'b1, 1'b1, 2'b00);
        check("R2 strobed write used", 4'b1011, 2'd0);
    endtask

    task automatic t_qualify();
        do_reset();
        write_reg(3'd1, 8'h01); // I/O enabled, E-high mode
        drive(16'h1234, 1'b0, 1'b1, 2'b00);
        check("R3 E mode, E low", 4'b1111, 2'd0);
        drive(16'h1234, 1'b1, 1'b0, 2'b00);
        check("R3 E mode, E high", 4'b1011, 2'd0);
        write_reg(3'd1, 8'h03); // address-valid mode
        drive(16'h1234, 1'b0, 1'b1, 2'b00);
        check("R3 AV mode, valid", 4'b1011, 2'd0);
        drive(16'h1234, 1'b1, 1'b0, 2'b00);
        check("R3 AV mode, not valid", 4'b1111, 2'd0);
    endtask

    task automatic t_io_range();
        do_reset();
        write_reg(3'd1, 8'h23); // 4K, stretch 2
        drive(16'h1000, 1'b0, 1'b1, 2'b00);
        check("R4 4K low edge / R12 stretch", 4'b1011, 2'd2);
        drive(16'h1FFF, 1'b0, 1'b1, 2'b00);
        check("R4 4K high edge", 4'b1011, 2'd2);
        drive(16'h0800, 1'b0, 1'b1, 2'b00);
        check("R4 4K excludes low page", 4'b1111, 2'd0);
        write_reg(3'd1, 8'h2B); // 8K
        drive(16'h0800, 1'b0, 1'b1, 2'b00);
        check("R4 8K includes low page", 4'b1011, 2'd2);
        drive(16'h2000, 1'b0, 1'b1, 2'b00);
        check("R4 8K upper bound", 4'b1111, 2'd0);
    endtask

    task automatic t_prog_range();
        do_reset();
        write_reg(3'd0, 8'h13); // upper half, stretch 1
        drive(16'h8000, 1'b0, 1'b1, 2'b00);
        check("R5 upper half start", 4'b0111, 2'd1);
        drive(16'h7FFF, 1'b0, 1'b1, 2'b00);
        check("R5 below upper half", 4'b1111, 2'd0);
        write_reg(3'd0, 8'h1B); // whole space
        drive(16'h7FFF, 1'b0, 1'b1, 2'b00);
        check("R5 whole space", 4'b0111, 2'd1);
    endtask

    task automatic t_gp_range();
        do_reset();
        write_reg(3'd2, 8'h03);
        write_reg(3'd3, 8'h40);
        write_reg(3'd4, 8'h03); // 2 KB block at 0x4000
        drive(16'h4000, 1'b0, 1'b1, 2'b00);
        check("R6 block start", 4'b1101, 2'd0);
        drive(16'h47FF, 1'b0, 1'b1, 2'b00);
        check("R6 block end", 4'b1101, 2'd0);
        drive(16'h4800, 1'b0, 1'b1, 2'b00);
        check("R6 past block", 4'b1111, 2'd0);
        drive(16'h3FFF, 1'b0, 1'b1, 2'b00);
        check("R6 before block", 4'b1111, 2'd0);
    endtask

    task automatic t_window();
        do_reset();
        write_reg(3'd5, 8'h0B); // GP2 tracks a window
        write_reg(3'd7, 8'h08); // window index 1
        drive(16'h2000, 1'b0, 1'b1, 2'b10);
        check("R7 selected window hit", 4'b1110, 2'd0);
        drive(16'h2000, 1'b0, 1'b1, 2'b01);
        check("R7 other window ignored", 4'b1111, 2'd0);
    endtask

    task automatic t_priority();
        do_reset();
        write_reg(3'd0, 8'h0B);             // prog whole space, prog first
        write_reg(3'd2, 8'h33); write_reg(3'd3, 8'h40); write_reg(3'd4, 8'h03);
        write_reg(3'd5, 8'h03); write_reg(3'd6, 8'h40); write_reg(3'd7, 8'h03);
        drive(16'h4000, 1'b0, 1'b1, 2'b00);
        check("R9 program first", 4'b0111, 2'd0);
        write_reg(3'd0, 8'h8B);             // general-purpose first
        drive(16'h4000, 1'b0, 1'b1, 2'b00);
        check("R9 GP first, GP1 over GP2 / R12", 4'b1101, 2'd3);
        write_reg(3'd2, 8'h00);             // GP1 off, GP2 next
        drive(16'h4000, 1'b0, 1'b1, 2'b00);
        check("R9 GP2 beats program", 4'b1110, 2'd0);
        write_reg(3'd1, 8'h1B);             // I/O 8K, stretch 1
        drive(16'h1000, 1'b0, 1'b1, 2'b00);
        check("R8 I/O over program", 4'b1011, 2'd1);
    endtask

    task automatic t_link();
        do_reset();
        write_reg(3'd2, 8'h83); write_reg(3'd3, 8'h40); write_reg(3'd4, 8'h03);
        drive(16'h4000, 1'b0, 1'b1, 2'b00);
        check("R10 GP1 mirrored to GP2", 4'b1100, 2'd0);
        write_reg(3'd2, 8'hF3);
        drive(16'h4000, 1'b0, 1'b1, 2'b00);
        check("R10 GP1 mirrored to program / R12", 4'b0100, 2'd3);
        write_reg(3'd2, 8'h00);
        write_reg(3'd5, 8'h43); write_reg(3'd6, 8'h40); write_reg(3'd7, 8'h03);
        drive(16'h4000, 1'b0, 1'b1, 2'b00);
        check("R10 GP2 mirrored to program", 4'b0110, 2'd0);
    endtask

    task automatic t_polarity();
        do_reset();
        write_reg(3'd2, 8'h87); write_reg(3'd3, 8'h40); write_reg(3'd4, 8'h03);
        write_reg(3'd5, 8'h04);             // GP2 off, active high
        drive(16'h4000, 1'b0, 1'b1, 2'b00);
        check("R11 both active high", 4'b1111, 2'd0);
        drive(16'h9000, 1'b0, 1'b1, 2'b00);
        check("R11 both idle low", 4'b1100, 2'd0);
        write_reg(3'd5, 8'h00);             // GP2 active low
        drive(16'h4000, 1'b0, 1'b1, 2'b00);
        check("R11 linked pin own polarity", 4'b1110, 2'd0);
    endtask

    initial begin
        t_reset();
        t_write_strobe();
        t_qualify();
        t_io_range();
        t_prog_range();
        t_gp_range();
        t_window();
        t_priority();
        t_link();
        t_polarity();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule